// File: doc/BRIEF.md
# Staircase Block Encoder with Transposed Coupling

This block turns a stream of short information rows into coded rows of a staircase forward-error-correction code. The code works on square blocks of M by M bits. Each row of a new block holds fresh information bits on the left and parity bits on the right. The parity is chosen so that the row, placed after the matching column of the previous coded block, forms a codeword of a (16,11) extended Hamming component code. Because the parity of every block is fed into the codewords of the next one, the coupling carries on for as long as the stream runs. The stream starts from an all-zero reference block.

Rows enter on a valid/ready input and leave on a valid/ready output, one coded row for each accepted row. A source may present a row whenever it likes; the row is taken on a clock edge where both `in_valid` and `in_ready` are high. The output holds its row and `out_valid` until the consumer raises `out_ready`. `in_ready` follows the output register: it is high when that register is empty or is being emptied in the same cycle, and it is low during `start`. Pulsing `start` begins a new stream. It clears the stored previous block to the reference and drops any row still waiting at the output.

Top module: `staircase_enc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The first block is encoded against an all-zero previous block.
- R2: Row r of a block is joined to column r of the previous coded block to form a 16-bit word w. Bit c of that column comes from row c, and it lands in w[c], which fills w[7:0]. The emitted row fills w[15:8]. For every emitted row, w has a zero syndrome.
- R3: The row layout is fixed. `out_row[2:0]` equals the accepted `in_info[2:0]`, and `out_row[7:3]` carries parity bits w[15:11].
- R4: The information positions w[0]..w[10] take the Hamming positions 3,5,6,7,9,10,11,12,13,14,15 in that order. Parity bit w[11+j] (j = 0..3) is the XOR of the information bits whose position has bit j set. Bit w[15] makes the weight of the whole word even.
- R5: The previous block used for block i+1 is block i in full, with its parity columns included. Parity therefore carries recursively from block to block.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_row` and `out_last` do not change.
- R7: `in_ready` equals (`out_valid` = 0 or `out_ready` = 1) whenever `start` is 0. An accepted row appears on the output in the next cycle, so with `out_ready` held high one row passes per cycle.
- R8: `out_last` is 1 exactly on the eighth row of each block.
- R9: `start` takes precedence over everything else. In its cycle `in_ready` is 0, and a valid input in that cycle is not taken. After it, `out_valid` is 0, the row count is back at 0, and the next block is encoded against all zeros.
- R10: Cycles with `in_valid` low leave the row count and the stored block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new stream from the zero reference |
| in_valid | input | 1 | Information row present |
| in_ready | output | 1 | Encoder takes the row on this edge |
| in_info | input | 3 | Information bits of one row |
| out_valid | output | 1 | Coded row present |
| out_ready | input | 1 | Consumer takes the coded row |
| out_row | output | 8 | Coded row: info in [2:0], parity in [7:3] |
| out_last | output | 1 | Row is the last of its block |

## Verification
Two things can land in the same cycle: a `start` pulse and an input row offered with `in_valid` high. The bench does this in the middle of a block while an earlier coded row still waits at the output. It then checks three things: `in_ready` is low in that cycle, `out_valid` is low after it, and the following block matches a model restarted from the zero reference. The other collision occurs at a block boundary. There the last row of a block leaves the output in the same cycle that the first row of the next block is taken and reads the block just stored. Unbroken streaming with `out_ready` high makes this happen, and the syndrome of every joined word is checked.

// File: rtl/staircase_pkg.sv
package staircase_pkg;
  parameter int SC_M    = 8;
  parameter int SC_INFO = 3;
  localparam int SC_N     = 2 * SC_M;
  localparam int SC_K     = SC_M + SC_INFO;
  localparam int SC_PAR   = SC_N - SC_K;
  localparam int SC_HBITS = SC_PAR - 1;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Hamming position of systematic bit k: k-th integer >= 3 that is not a power of two
  function automatic int data_pos(input int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 256; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == k && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/sc_parity_gen.sv
module sc_parity_gen #(
  parameter int K   = staircase_pkg::SC_K,
  parameter int PAR = staircase_pkg::SC_PAR
) (
  input  logic [K-1:0]   data,
  output logic [PAR-1:0] parity
);
  localparam int HB = PAR - 1;

  logic [HB-1:0] ham;

  genvar j;
  generate
    for (j = 0; j < HB; j++) begin : g_ham
      always_comb begin
        ham[j] = 1'b0;
        for (int k = 0; k < K; k++) begin
          if (((staircase_pkg::data_pos(k) >> j) & 1) == 1) ham[j] = ham[j] ^ data[k];
        end
      end
    end
  endgenerate

  always_comb begin
    parity[HB-1:0] = ham;
    parity[HB]     = (^data) ^ (^ham);
  end
endmodule

// File: rtl/sc_row_ctrl.sv
module sc_row_ctrl #(
  parameter int M = staircase_pkg::SC_M
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 accept,
  output logic [$clog2(M)-1:0] row_idx,
  output logic                 last_row
);
  localparam int RW = $clog2(M);
  localparam logic [RW-1:0] LAST = RW'(M - 1);

  assign last_row = (row_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || start)  row_idx <= '0;
    else if (accept)      row_idx <= last_row ? '0 : row_idx + 1'b1;
  end

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start && last_row) |=> (row_idx == '0));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start) |=> $stable(row_idx));
endmodule

// File: rtl/sc_coupling_mem.sv
module sc_coupling_mem #(
  parameter int M = staircase_pkg::SC_M
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 accept,
  input  logic                 last_row,
  input  logic [$clog2(M)-1:0] row_idx,
  input  logic [M-1:0]         new_row,
  output logic [M-1:0]         coupled
);
  localparam int RW = $clog2(M);

  logic [M-1:0] prev_q [M];
  logic [M-1:0] cur_q  [M];

  // transpose read: bit c of the coupled word is row c, column row_idx of the stored block
  genvar c;
  generate
    for (c = 0; c < M; c++) begin : g_col
      assign coupled[c] = prev_q[c][row_idx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      for (int k = 0; k < M; k++) prev_q[k] <= '0;
    end else if (accept && last_row) begin
      for (int k = 0; k < M; k++) prev_q[k] <= (RW'(k) == row_idx) ? new_row : cur_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < M; k++) cur_q[k] <= '0;
    end else if (accept) begin
      cur_q[row_idx] <= new_row;
    end
  end

  a_r9_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (coupled == '0));
endmodule

// File: rtl/staircase_enc.sv
module staircase_enc #(
  parameter int M    = staircase_pkg::SC_M,
  parameter int INFO = staircase_pkg::SC_INFO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [INFO-1:0] in_info,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [M-1:0]    out_row,
  output logic            out_last
);
  localparam int N   = 2 * M;
  localparam int K   = M + INFO;
  localparam int PAR = N - K;
  localparam int RW  = $clog2(M);

  logic          accept;
  logic [RW-1:0] row_idx;
  logic          last_row;
  logic [M-1:0]  coupled;
  logic [K-1:0]  sys_bits;
  logic [PAR-1:0] parity;
  logic [M-1:0]  coded_row;

  assign in_ready  = !start && (!out_valid || out_ready);
  assign accept    = in_valid && in_ready;
  assign sys_bits  = {in_info, coupled};
  assign coded_row = {parity, in_info};

  sc_row_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .row_idx(row_idx), .last_row(last_row)
  );

  sc_coupling_mem #(.M(M)) u_mem (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .last_row(last_row), .row_idx(row_idx), .new_row(coded_row),
    .coupled(coupled)
  );

  sc_parity_gen #(.K(K), .PAR(PAR)) u_par (
    .data(sys_bits), .parity(parity)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_last  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_row   <= coded_row;
      out_last  <= last_row;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_row) && $stable(out_last)));
  a_r7_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  a_r3_info_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_row[INFO-1:0] == $past(in_info)));
  a_r9_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);
endmodule

// File: tb/staircase_enc_tb.sv
module staircase_enc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_info = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_row;
  logic out_last;

  always #10 clk = ~clk;

  staircase_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_info(in_info), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_last(out_last)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [7:0]  ref_prev [8];
  logic [7:0]  ref_cur  [8];
  int          ref_row;
  logic [7:0]  q_row  [16];
  logic [15:0] q_cw   [16];
  logic        q_last [16];
  int          q_head, q_tail;
  logic        last_acc;
  logic [7:0]  held_row;
  logic        held_last;
  logic        held_pend;
  logic [7:0]  lfsr = 8'hA5;

  function automatic int hpos(input int k);
    case (k)
      0: return 3;  1: return 5;  2: return 6;  3: return 7;
      4: return 9;  5: return 10; 6: return 11; 7: return 12;
      8: return 13; 9: return 14; default: return 15;
    endcase
  endfunction

  function automatic logic [4:0] syndrome(input logic [15:0] w);
    logic [4:0] s;
    s = '0;
    for (int k = 0; k < 11; k++) if (w[k]) s[3:0] = s[3:0] ^ 4'(hpos(k));
    s[3:0] = s[3:0] ^ {w[14], w[13], w[12], w[11]};
    s[4] = ^w;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 8; r++) begin ref_prev[r] = '0; ref_cur[r] = '0; end
    ref_row = 0; q_head = 0; q_tail = 0; held_pend = 0; last_acc = 0;
  endtask

  task automatic model_accept(input logic [2:0] info);
    logic [10:0] d;
    logic [4:0]  p;
    logic [15:0] w;
    logic [7:0]  row;
    for (int c = 0; c < 8; c++) d[c] = ref_prev[c][ref_row];
    d[10:8] = info;
    p = '0;
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 11; k++)
        if (((hpos(k) >> j) & 1) == 1) p[j] = p[j] ^ d[k];
    p[4] = (^d) ^ (^p[3:0]);
    row = {p, info};
    w = {row, d[7:0]};
    q_row[q_tail % 16] = row; q_cw[q_tail % 16] = w; q_last[q_tail % 16] = (ref_row == 7);
    q_tail++;
    ref_cur[ref_row] = row;
    if (ref_row == 7) begin
      for (int r = 0; r < 8; r++) ref_prev[r] = ref_cur[r];
      ref_row = 0;
    end else ref_row++;
  endtask

  // one cycle: drive at negedge, judge what will happen at the next rising edge
  task automatic step(input logic v, input logic [2:0] info, input logic ordy, input logic st);
    @(negedge clk);
    in_valid = v; in_info = info; out_ready = ordy; start = st;
    #1;
    if (held_pend) begin // R6
      chk(out_valid == 1'b1, "R6 valid held", 32'(out_valid), 1);
      chk(out_row == held_row && out_last == held_last, "R6 row held",
          32'({out_last, out_row}), 32'({held_last, held_row}));
    end
    if (last_acc) chk(out_valid == 1'b1, "R7 one-cycle latency", 32'(out_valid), 1);
    if (st) begin
      chk(in_ready == 1'b0, "R9 in_ready low during start", 32'(in_ready), 0);
      model_clear();
      return;
    end
    chk(in_ready == (!out_valid || ordy), "R7 ready rule", 32'(in_ready), 32'(!out_valid || ordy));
    held_pend = out_valid && !ordy;
    held_row = out_row; held_last = out_last;
    if (out_valid && ordy) begin
      if (q_head == q_tail) chk(1'b0, "R7 unexpected output", 32'(out_row), 0);
      else begin
        chk(out_row == q_row[q_head % 16], "R3 R4 R5 coded row",
            32'(out_row), 32'(q_row[q_head % 16]));
        chk(syndrome({out_row, q_cw[q_head % 16][7:0]}) == '0, "R2 syndrome",
            32'(syndrome({out_row, q_cw[q_head % 16][7:0]})), 0);
        chk(out_last == q_last[q_head % 16], "R8 last flag", 32'(out_last), 32'(q_last[q_head % 16]));
        q_head++;
      end
    end
    last_acc = v && in_ready;
    if (last_acc) model_accept(info);
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic drain();
    for (int i = 0; i < 4; i++) step(1'b0, 3'b000, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);
    // first block against the zero reference
    for (int r = 0; r < 8; r++) step(1'b1, 3'(r), 1'b1, 1'b0); // R1
    drain();
  endtask

  task automatic t_stream();
    // R5: several consecutive blocks, parity recursion, back-to-back boundaries
    for (int i = 0; i < 32; i++) begin
      lfsr = nxt(lfsr);
      step(1'b1, lfsr[2:0], 1'b1, 1'b0);
    end
    drain();
  endtask

  task automatic t_backpressure();
    // R6 stalls and R10 idle gaps
    for (int i = 0; i < 48; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[3] | lfsr[6], lfsr[2:0], lfsr[5] ^ lfsr[1], 1'b0);
    end
    for (int i = 0; i < 6; i++) step(1'b0, 3'b111, 1'b1, 1'b0); // R10 idle
    drain();
  endtask

  task automatic t_start_collision();
    for (int i = 0; i < 5; i++) step(1'b1, 3'(i + 2), 1'b1, 1'b0);
    step(1'b1, 3'b101, 1'b0, 1'b0);       // leave a row pending
    step(1'b1, 3'b110, 1'b1, 1'b1);       // start with valid input: R9
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R9 output dropped", 32'(out_valid), 0);
    for (int i = 0; i < 16; i++) begin
      lfsr = nxt(lfsr);
      step(1'b1, lfsr[2:0], 1'b1, 1'b0);
    end
    drain();
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream();
    t_backpressure();
    t_start_collision();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule